// File: doc/BRIEF.md
# Conditional Memory-Mapped Transfer Engine

This block copies words from one location in a flat memory-mapped address space to another. Locations can be RAMs, FIFO ports, registers or operator ports. A host hands it one instruction at a time. The instruction sets a starting source address, a starting destination address, a separate step for each side, and a word count. It can also enable a condition and pick how the engine reacts to that condition. The engine fetches words on a read port, keeps each word in a single holding slot, and delivers it on a write port. Both ports use a valid/ready handshake.

A step of zero pins that side to one address, which suits FIFO ports. Larger steps give strided access. A count of zero turns the instruction into an endless link, which runs until something aborts it. The condition is one Boolean input computed outside the block. Three reactions are available:

- Gate the start: no word moves until the condition is seen true.
- Pause: the transfer holds while the condition is true and then resumes.
- Kill: the transfer ends at once when the condition is true.

The host can also end any transfer at once with a synchronous abort pulse.

Top module: `xfer_engine`

## Requirements
- R1: An instruction is taken only on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high exactly when `busy` is low. While idle, neither `rd_valid` nor `wr_valid` is asserted. After reset the engine is idle with `done` and `aborted` low.
- R2: The k-th word (k from 0) is read from source + k*src_inc and written to destination + k*dst_inc, computed modulo 2^32. The data written is the data read, in the same order. An address changes only when a word is transferred on its own port.
- R3: A step of 0 keeps that side at its start address for the whole transfer.
- R4: A counted transfer of N words (N > 0) performs exactly N writes. `done` is high for exactly one cycle, in the cycle right after the last write handshake, and `busy` is low in that same cycle.
- R5: A word is read only in a cycle where `rd_ready` is high. The word stays on the write port until `wr_ready` accepts it. With both ports ready, one word is written per clock.
- R6: A count of 0 is an endless link. Words keep moving and `done` never pulses.
- R7: Reaction code 1 (gate start) with the condition enabled: no read is issued until `cond_in` has been high. After that, the transfer runs to its end even if `cond_in` falls again.
- R8: Reaction code 2 (pause) with the condition enabled: while `cond_in` is high, no read or write handshake happens and `busy` stays high. Once it falls, the transfer continues from where it stopped. No word is lost or repeated.
- R9: Reaction code 3 (kill) with the condition enabled: `wr_valid` is low in any cycle where `cond_in` is high. In the next cycle `busy` is low, `aborted` is high, and any held word is dropped.
- R10: A one-cycle `host_abort` while busy ends any transfer, including an endless link. In the next cycle `busy` is low and `aborted` is high. `aborted` clears when the next instruction is taken.
- R11: With `cmd_cond_en` low, `cond_in` has no effect on the transfer, whatever reaction code is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Instruction offered |
| cmd_ready | output | 1 | Engine idle, instruction can be taken |
| cmd_src | input | 32 | Starting source address |
| cmd_dst | input | 32 | Starting destination address |
| cmd_src_inc | input | 8 | Source step per word (unsigned) |
| cmd_dst_inc | input | 8 | Destination step per word (unsigned) |
| cmd_count | input | 16 | Word count, 0 = endless link |
| cmd_cond_en | input | 1 | Enable the condition |
| cmd_react | input | 2 | Reaction: 0 none, 1 gate start, 2 pause, 3 kill |
| cond_in | input | 1 | External Boolean condition |
| host_abort | input | 1 | End the current transfer |
| rd_valid | output | 1 | Read request |
| rd_addr | output | 32 | Read address |
| rd_ready | input | 1 | Read data available this cycle |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | Write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write accepted this cycle |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a counted transfer ends |
| aborted | output | 1 | The last transfer was killed |

## Verification
The checks assume the host drives `cmd_valid` low out of reset, so that the first rise of `busy` can be traced back to an offered instruction. They also assume the read slave returns valid data in the same cycle it raises `rd_ready`. The stimulus follows both rules: the bench drives every input from reset onward, and it computes read data combinationally from the read address. Because read data depends only on the address, any wrong source address or lost word shows up as a data mismatch at the write port. The bench changes ready, condition and abort inputs only just after the falling clock edge, so every condition change lines up with a whole cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    RX_NONE     = 2'd0,
    RX_ACTIVATE = 2'd1,
    RX_SUSPEND  = 2'd2,
    RX_ABORT    = 2'd3
  } react_e;
endpackage

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [INC_W-1:0]  inc,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  logic [INC_W-1:0] inc_q;

  // Unsigned step, wraps modulo 2^ADDR_W.
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [INC_W-1:0] s);
    return a + ADDR_W'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      inc_q <= '0;
    end else if (load) begin
      addr  <= base;
      inc_q <= inc;
    end else if (step) begin
      addr  <= next_addr(addr, inc_q);
    end
  end
endmodule

// File: rtl/xfer_buf.sv
module xfer_buf #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              drain,
  input  logic [DATA_W-1:0] din,
  output logic              full,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (clr) begin
      full <= 1'b0;
    end else begin
      if (load) begin
        full <= 1'b1;
        dout <= din;
      end else if (drain) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             cond_en,
  input  logic [1:0]       react,
  input  logic             cond_in,
  input  logic             host_abort,
  input  logic             buf_full,
  input  logic             rd_ready,
  input  logic             wr_ready,
  output logic             busy,
  output logic             rd_req,
  output logic             wr_req,
  output logic             rd_fire,
  output logic             wr_fire,
  output logic             ev_stop,
  output logic             ev_pause,
  output logic             done,
  output logic             aborted
);
  react_e           react_q;
  logic             cen_q, armed_q, endless_q;
  logic [CNT_W-1:0] rd_left, wr_left;
  logic             cond_hit, waiting, reads_left, last_wr;

  always_comb begin
    cond_hit   = busy && cen_q && cond_in;
    ev_stop    = busy && (host_abort || (cond_hit && react_q == RX_ABORT));
    ev_pause   = cond_hit && react_q == RX_SUSPEND;
    waiting    = cen_q && react_q == RX_ACTIVATE && !armed_q && !cond_in;
    reads_left = endless_q || rd_left != '0;
    wr_req     = busy && buf_full && !ev_stop && !ev_pause;
    wr_fire    = wr_req && wr_ready;
    rd_req     = busy && reads_left && !ev_stop && !ev_pause && !waiting
                 && (!buf_full || wr_fire);
    rd_fire    = rd_req && rd_ready;
    last_wr    = wr_fire && !endless_q && wr_left == CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      aborted   <= 1'b0;
      react_q   <= RX_NONE;
      cen_q     <= 1'b0;
      armed_q   <= 1'b0;
      endless_q <= 1'b0;
      rd_left   <= '0;
      wr_left   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        aborted   <= 1'b0;
        react_q   <= react_e'(react);
        cen_q     <= cond_en;
        armed_q   <= 1'b0;
        endless_q <= count == '0;
        rd_left   <= count;
        wr_left   <= count;
      end else if (busy) begin
        if (ev_stop) begin
          busy    <= 1'b0;
          aborted <= 1'b1;
        end else begin
          if (cond_in) armed_q <= 1'b1;
          if (rd_fire && !endless_q) rd_left <= rd_left - CNT_W'(1);
          if (wr_fire && !endless_q) wr_left <= wr_left - CNT_W'(1);
          if (last_wr) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int INC_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_src,
  input  logic [ADDR_W-1:0] cmd_dst,
  input  logic [INC_W-1:0]  cmd_src_inc,
  input  logic [INC_W-1:0]  cmd_dst_inc,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_cond_en,
  input  logic [1:0]        cmd_react,
  input  logic              cond_in,
  input  logic              host_abort,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ready,
  output logic              busy,
  output logic              done,
  output logic              aborted
);
  logic start, rd_fire, wr_fire, buf_full, ev_stop, ev_pause;

  assign cmd_ready = !busy;
  assign start     = cmd_valid && !busy;

  xfer_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .count(cmd_count),
    .cond_en(cmd_cond_en), .react(cmd_react), .cond_in(cond_in),
    .host_abort(host_abort), .buf_full(buf_full), .rd_ready(rd_ready),
    .wr_ready(wr_ready), .busy(busy), .rd_req(rd_valid), .wr_req(wr_valid),
    .rd_fire(rd_fire), .wr_fire(wr_fire), .ev_stop(ev_stop),
    .ev_pause(ev_pause), .done(done), .aborted(aborted)
  );

  xfer_addr_gen #(.ADDR_W(ADDR_W), .INC_W(INC_W)) i_src (
    .clk(clk), .rst_n(rst_n), .load(start), .base(cmd_src),
    .inc(cmd_src_inc), .step(rd_fire), .addr(rd_addr)
  );

  xfer_addr_gen #(.ADDR_W(ADDR_W), .INC_W(INC_W)) i_dst (
    .clk(clk), .rst_n(rst_n), .load(start), .base(cmd_dst),
    .inc(cmd_dst_inc), .step(wr_fire), .addr(wr_addr)
  );

  xfer_buf #(.DATA_W(DATA_W)) i_buf (
    .clk(clk), .rst_n(rst_n), .clr(start || ev_stop), .load(rd_fire),
    .drain(wr_fire), .din(rd_data), .full(buf_full), .dout(wr_data)
  );
endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              busy,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done,
  input logic              aborted,
  input logic              ev_stop,
  input logic              ev_pause
);
  AST_ACCEPT_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_valid && !wr_valid)); // R1
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(rd_valid && rd_ready)) |=> $stable(rd_addr)); // R2
  AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(wr_valid && wr_ready)) |=> $stable(wr_addr)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
  AST_PAUSE_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pause && !ev_stop) |=> busy); // R8
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!busy && aborted)); // R9
endmodule

bind xfer_engine xfer_engine_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .done(done), .aborted(aborted), .ev_stop(ev_stop), .ev_pause(ev_pause)
);

// File: tb/test_xfer_engine.sv
module test_xfer_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cmd_valid, cmd_ready, cmd_cond_en, cond_in, host_abort;
  logic [31:0] cmd_src, cmd_dst, rd_addr, rd_data, wr_addr, wr_data;
  logic [7:0]  cmd_src_inc, cmd_dst_inc;
  logic [15:0] cmd_count;
  logic [1:0]  cmd_react;
  logic        rd_valid, rd_ready, wr_valid, wr_ready, busy, done, aborted;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, a[31:16]};
  endfunction
  assign rd_data = mem_word(rd_addr);

  xfer_engine i_xfer_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_src_inc(cmd_src_inc),
    .cmd_dst_inc(cmd_dst_inc), .cmd_count(cmd_count), .cmd_cond_en(cmd_cond_en),
    .cmd_react(cmd_react), .cond_in(cond_in), .host_abort(host_abort),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .busy(busy), .done(done), .aborted(aborted)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_wr = 0, n_done = 0, first_wr = -1, last_wr = -1;
  logic [31:0] q_a[$], q_d[$];
  bit rnd_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Ready drivers: change just after the falling edge.
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready = rnd_mode ? lfsr[0] : 1'b1;
    wr_ready = rnd_mode ? lfsr[3] : 1'b1;
  end

  // Monitor: sample shortly before the rising edge and score writes.
  always begin
    @(negedge clk);
    #4;
    if (wr_valid && wr_ready) begin
      n_wr++;
      if (first_wr < 0) first_wr = cyc;
      last_wr = cyc;
      if (q_a.size() == 0) chk(1'b0, "R4 write beyond expected words", wr_addr, 32'h0);
      else begin
        logic [31:0] ea, ed;
        ea = q_a.pop_front();
        ed = q_d.pop_front();
        chk(wr_addr == ea, "R2 write address", wr_addr, ea);
        chk(wr_data == ed, "R2 write data", wr_data, ed);
      end
    end
    if (done) n_done++;
  end

  task automatic expect_words(input logic [31:0] src, input logic [31:0] dst,
                              input logic [7:0] si, input logic [7:0] di, input int n);
    logic [31:0] s, d;
    s = src;
    d = dst;
    for (int k = 0; k < n; k++) begin
      q_a.push_back(d);
      q_d.push_back(mem_word(s));
      s = s + 32'(si);
      d = d + 32'(di);
    end
  endtask

  task automatic issue(input logic [31:0] src, input logic [31:0] dst,
                       input logic [7:0] si, input logic [7:0] di,
                       input logic [15:0] n, input bit cen, input logic [1:0] rc);
    @(negedge clk);
    cmd_src = src; cmd_dst = dst; cmd_src_inc = si; cmd_dst_inc = di;
    cmd_count = n; cmd_cond_en = cen; cmd_react = rc; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic clear_stats();
    n_wr = 0; n_done = 0; first_wr = -1; last_wr = -1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R4 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_src = '0; cmd_dst = '0; cmd_src_inc = '0;
    cmd_dst_inc = '0; cmd_count = '0; cmd_cond_en = 1'b0; cmd_react = '0;
    cond_in = 1'b0; host_abort = 1'b0; rd_ready = 1'b1; wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(cmd_ready && !busy, "R1 idle after reset", {30'd0, cmd_ready, busy}, 32'h2);
    chk(!rd_valid && !wr_valid && !done && !aborted, "R1 quiet after reset",
        {28'd0, rd_valid, wr_valid, done, aborted}, 32'h0);

    // R4 R5 counted copy, both ports always ready
    clear_stats();
    expect_words(32'h0000_1000, 32'h0000_8000, 8'd1, 8'd1, 8);
    issue(32'h0000_1000, 32'h0000_8000, 8'd1, 8'd1, 16'd8, 1'b0, 2'd0);
    wait_idle();
    chk(n_wr == 8, "R4 word count", n_wr, 8);
    chk(n_done == 1, "R4 single done pulse", n_done, 1);
    chk(!busy && !aborted, "R4 idle after done", {busy, aborted}, 0);
    chk(last_wr - first_wr == 7, "R5 one word per clock", last_wr - first_wr, 7);
    chk(q_a.size() == 0, "R4 all expected words written", q_a.size(), 0);

    // R3 R2 fixed source, stride 4 destination wrapping at 2^32, random readiness
    clear_stats();
    rnd_mode = 1'b1;
    expect_words(32'h0000_4000, 32'hFFFF_FFF0, 8'd0, 8'd4, 9);
    issue(32'h0000_4000, 32'hFFFF_FFF0, 8'd0, 8'd4, 16'd9, 1'b0, 2'd0);
    wait_idle();
    rnd_mode = 1'b0;
    chk(n_wr == 9 && q_a.size() == 0, "R3 fixed-source stride copy complete", n_wr, 9);
    chk(n_done == 1, "R5 done under stalls", n_done, 1);

    // R6 R10 endless link ended by the host
    clear_stats();
    expect_words(32'h0000_2000, 32'h0000_9000, 8'd1, 8'd0, 200);
    issue(32'h0000_2000, 32'h0000_9000, 8'd1, 8'd0, 16'd0, 1'b0, 2'd0);
    repeat (30) @(negedge clk);
    host_abort = 1'b1;
    @(negedge clk);
    host_abort = 1'b0;
    #1;
    chk(!busy && aborted, "R10 host abort ends link", {busy, aborted}, 1);
    chk(n_done == 0, "R6 endless link gives no done", n_done, 0);
    chk(n_wr >= 25, "R6 link keeps moving words", n_wr, 25);
    q_a.delete(); q_d.delete();

    // R7 gate-start reaction (code 1); R10 aborted cleared on accept
    clear_stats();
    expect_words(32'h0000_3000, 32'h0000_A000, 8'd1, 8'd1, 4);
    issue(32'h0000_3000, 32'h0000_A000, 8'd1, 8'd1, 16'd4, 1'b1, 2'd1);
    #1;
    chk(!aborted, "R10 aborted cleared by new instruction", aborted, 0);
    repeat (10) @(negedge clk);
    #1;
    chk(n_wr == 0 && !rd_valid && busy, "R7 waits for condition", n_wr, 0);
    @(negedge clk);
    cond_in = 1'b1;
    @(negedge clk);
    cond_in = 1'b0;
    wait_idle();
    chk(n_wr == 4 && n_done == 1, "R7 runs after condition", n_wr, 4);

    // R8 pause reaction (code 2)
    clear_stats();
    expect_words(32'h0000_5000, 32'h0000_B000, 8'd1, 8'd1, 10);
    issue(32'h0000_5000, 32'h0000_B000, 8'd1, 8'd1, 16'd10, 1'b1, 2'd2);
    for (int i = 0; i < 100 && n_wr < 3; i++) @(negedge clk);
    cond_in = 1'b1;
    begin
      int base;
      base = n_wr;
      repeat (6) @(negedge clk);
      #1;
      chk(n_wr == base && busy, "R8 no writes while paused", n_wr, base);
    end
    cond_in = 1'b0;
    wait_idle();
    chk(n_wr == 10 && q_a.size() == 0, "R8 resume without loss", n_wr, 10);
    chk(n_done == 1 && !aborted, "R8 completes normally", n_done, 1);

    // R9 kill reaction (code 3)
    clear_stats();
    expect_words(32'h0000_6000, 32'h0000_C000, 8'd1, 8'd1, 20);
    issue(32'h0000_6000, 32'h0000_C000, 8'd1, 8'd1, 16'd20, 1'b1, 2'd3);
    for (int i = 0; i < 100 && n_wr < 5; i++) @(negedge clk);
    cond_in = 1'b1;
    #2;
    chk(!wr_valid, "R9 no write in kill cycle", wr_valid, 0);
    @(negedge clk);
    #1;
    chk(!busy && aborted, "R9 engine idle and aborted", {busy, aborted}, 1);
    chk(n_wr < 20 && n_done == 0, "R9 transfer cut short", n_wr, 5);
    cond_in = 1'b0;
    q_a.delete(); q_d.delete();

    // R11 condition disabled: cond_in ignored
    clear_stats();
    cond_in = 1'b1;
    expect_words(32'h0000_7000, 32'h0000_D000, 8'd2, 8'd3, 6);
    issue(32'h0000_7000, 32'h0000_D000, 8'd2, 8'd3, 16'd6, 1'b0, 2'd3);
    wait_idle();
    chk(n_wr == 6 && n_done == 1 && !aborted, "R11 condition ignored", n_wr, 6);
    cond_in = 1'b0;

    // R1 instruction offered while busy is not taken
    clear_stats();
    expect_words(32'h0001_0000, 32'h0002_0000, 8'd1, 8'd1, 12);
    issue(32'h0001_0000, 32'h0002_0000, 8'd1, 8'd1, 16'd12, 1'b0, 2'd0);
    cmd_src = 32'h0BAD_0000; cmd_dst = 32'h0BAD_1000; cmd_count = 16'd3;
    cmd_valid = 1'b1;
    #1;
    chk(!cmd_ready, "R1 not ready while busy", cmd_ready, 0);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    chk(n_wr == 12 && q_a.size() == 0, "R1 busy instruction ignored", n_wr, 12);
    chk(n_done == 1, "R1 single completion", n_done, 1);

    summary();
    $finish;
  end
endmodule